// File: doc/BRIEF.md
# Rotating Mailbox Command Writer

This block hands short command messages from a host-side request port to an embedded controller through a small set of mailbox slots. The slots are used in strict rotation. Each request carries an 8-bit element identifier, a payload length and up to five payload bytes. The block picks the current slot and checks that the controller has consumed that slot's previous message. It then packs the message into a 4-byte main register, plus a 2-byte extension register when the message is long. Finally it emits the bytes one per cycle on a byte-wide register write port.

Readiness is polled on a microsecond tick taken from a clock divider. A slot that stays busy past a bounded number of polls ends the request with a timeout pulse. A request made while the controller is flagged as not ready is refused at once. Every request ends in exactly one of three one-cycle pulses: done, timeout or reject. The main register of slot `s` sits at `MAIN_BASE + 4*s + byte`. The extension register sits at `EXT_BASE + 2*s + byte`.

Top module: `mbox_writer`

## Requirements
- R1: Slots are used in the order 0,1,...,NSLOT-1,0. The slot pointer advances only on a done outcome. Timeout and reject leave it unchanged.
- R2: Slot `s` is ready only when bit `s` of `fw_pend_i` is 0 and byte `s` of `slot_stat_i` (bits `8s+7:8s`) is 0. No write starts while the current slot is not ready. Pending bits of other slots have no effect.
- R3: While the slot is not ready, it is re-checked every POLL_US ticks. After POLL_MAX re-checks that still find it busy, `timeout_o` pulses and nothing is written. With TICK_DIV=2, POLL_US=3 and POLL_MAX=4, the pulse comes 25 to 29 cycles after acceptance.
- R4: For lengths 1 to 3 there are four writes, to main addresses 0..3 of the slot. Byte 0 is the identifier with bit 7 cleared. Bytes 1..3 are payload bytes 0..2. Payload byte `i` is `req_data_i[8i+7:8i]`, and any byte at index `len` or above is written as 0.
- R5: For lengths 4 and 5 there are six writes. Payload bytes 0 and 1 go to extension bytes 0 and 1. The main register then holds the identifier with bit 7 set, followed by payload bytes 2, 3 and 4 (byte 4 is 0 when the length is 4).
- R6: Writes occur on consecutive cycles. The extension bytes come first, then main bytes in ascending order, so main byte 3 is always the last write.
- R7: A length of 0, 6 or 7 still waits for slot readiness, but writes nothing. It then signals done and advances the slot pointer, 1 cycle after acceptance when the slot is ready.
- R8: When `fw_ready_i` is 0 at acceptance, `reject_o` pulses in the next cycle. Nothing is written and the slot pointer is unchanged.
- R9: `req_ready_o` is 1 after reset and while idle. It is 0 from the cycle after acceptance until the outcome pulse.
- R10: With a ready slot, done pulses N+1 cycles after acceptance, where N is the number of writes (4 or 6). At most one outcome pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fw_ready_i | input | 1 | Controller ready to accept commands |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request taken this cycle |
| req_id_i | input | 8 | Element identifier |
| req_len_i | input | 3 | Payload length, 1 to 5 are valid |
| req_data_i | input | 40 | Payload, byte i at bits 8i+7:8i |
| fw_pend_i | input | 8 | Shared pending byte, bit s for slot s |
| slot_stat_i | input | NSLOT*8 | Per-slot status bytes, slot s at bits 8s+7:8s |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | ADDR_W | Register byte address |
| wr_data_o | output | 8 | Register write data |
| done_o | output | 1 | Request completed (pulse) |
| timeout_o | output | 1 | Slot never freed (pulse) |
| reject_o | output | 1 | Controller not ready (pulse) |

## Verification
Acceptance is the rising edge at which `req_valid_i` and `req_ready_o` are both high, and every result is counted in cycles from that edge. The reject pulse is due in the cycle directly after acceptance. Done for an invalid length is due one cycle after, and done for a ready slot is due N+1 cycles after, following N write strobes in the intervening cycles. The timeout pulse lands in a window fixed by the divider phase. The bench drives on falling edges and samples outputs on falling edges, numbering each falling edge after acceptance, so every latency is compared against the exact count above. Write strobes are logged at the same falling edges and compared byte by byte, with addresses, against expectations computed from the slot rotation.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned PAY_BYTES = 5;
  localparam int unsigned SEQ_MAX   = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WAIT, ST_WRITE} seq_state_e;

  // bytes in emission order; ext messages put extension bytes first
  typedef struct packed {
    logic [SEQ_MAX-1:0][7:0] bytes;
    logic [2:0]              nwr;
    logic                    ext;
    logic                    len_ok;
  } mbox_cmd_t;
endpackage

// File: rtl/mbox_tick.sv
module mbox_tick #(
  parameter int unsigned DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(DIV - 1));
  assign tick_o = wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mbox_packer.sv
module mbox_packer
  import mbox_pkg::*;
(
  input  logic [7:0]             id_i,
  input  logic [2:0]             len_i,
  input  logic [PAY_BYTES*8-1:0] data_i,
  output mbox_cmd_t              cmd_o
);
  logic [PAY_BYTES-1:0][7:0] pay;

  always_comb begin
    for (int i = 0; i < PAY_BYTES; i++)
      pay[i] = (32'(len_i) > i) ? data_i[8*i +: 8] : 8'h00;
  end

  always_comb begin
    cmd_o = '0;
    unique case (len_i)
      3'd1, 3'd2, 3'd3: begin
        cmd_o.bytes[0] = {1'b0, id_i[6:0]};
        cmd_o.bytes[1] = pay[0];
        cmd_o.bytes[2] = pay[1];
        cmd_o.bytes[3] = pay[2];
        cmd_o.nwr      = 3'd4;
        cmd_o.len_ok   = 1'b1;
      end
      3'd4, 3'd5: begin
        cmd_o.bytes[0] = pay[0];
        cmd_o.bytes[1] = pay[1];
        cmd_o.bytes[2] = {1'b1, id_i[6:0]};
        cmd_o.bytes[3] = pay[2];
        cmd_o.bytes[4] = pay[3];
        cmd_o.bytes[5] = pay[4];
        cmd_o.nwr      = 3'd6;
        cmd_o.ext      = 1'b1;
        cmd_o.len_ok   = 1'b1;
      end
      default: cmd_o = '0;
    endcase
  end
endmodule

// File: rtl/mbox_ready.sv
module mbox_ready #(
  parameter int unsigned NSLOT = 4
) (
  input  logic [7:0]         pend_i,
  input  logic [NSLOT*8-1:0] stat_i,
  output logic [NSLOT-1:0]   rdy_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign rdy_o[s] = !pend_i[s] && (stat_i[8*s +: 8] == 8'h00);
  end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int unsigned NSLOT     = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned MAIN_BASE = 16,
  parameter int unsigned EXT_BASE  = 48,
  parameter int unsigned POLL_US   = 10,
  parameter int unsigned POLL_MAX  = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fw_ready_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  mbox_cmd_t         cmd_i,
  input  logic [NSLOT-1:0]  rdy_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              reject_o
);
  localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int unsigned PU_W   = $clog2(POLL_US + 1);
  localparam int unsigned PM_W   = $clog2(POLL_MAX + 1);

  seq_state_e        state_q;
  logic [SLOT_W-1:0] slot_q, slot_nxt;
  mbox_cmd_t         cmd_q;
  logic [2:0]        idx_q, main_idx;
  logic [PU_W-1:0]   tcnt_q;
  logic [PM_W-1:0]   pcnt_q;
  logic              done_q, tmo_q, rej_q;
  logic              slot_rdy, accept, in_ext, last_wr;

  assign slot_rdy    = rdy_i[slot_q];
  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign slot_nxt    = (slot_q == SLOT_W'(NSLOT - 1)) ? '0 : slot_q + 1'b1;
  assign last_wr     = (idx_q == cmd_q.nwr - 3'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      cmd_q   <= '0;
      idx_q   <= '0;
      tcnt_q  <= '0;
      pcnt_q  <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      tmo_q  <= 1'b0;
      rej_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (!fw_ready_i) rej_q <= 1'b1;
          else begin
            cmd_q   <= cmd_i;
            pcnt_q  <= '0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (slot_rdy) begin
            if (cmd_q.len_ok) begin
              idx_q   <= '0;
              state_q <= ST_WRITE;
            end else begin
              done_q  <= 1'b1;
              slot_q  <= slot_nxt;
              state_q <= ST_IDLE;
            end
          end else if (pcnt_q == PM_W'(POLL_MAX)) begin
            tmo_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            tcnt_q  <= '0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (tick_i) begin
          if (tcnt_q == PU_W'(POLL_US - 1)) begin
            pcnt_q  <= pcnt_q + 1'b1;
            state_q <= ST_CHECK;
          end else begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_WRITE: begin
          if (last_wr) begin
            done_q  <= 1'b1;
            slot_q  <= slot_nxt;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // extension bytes occupy the first two emission slots
  assign in_ext   = cmd_q.ext && (idx_q < 3'd2);
  assign main_idx = cmd_q.ext ? idx_q - 3'd2 : idx_q;

  always_comb begin
    if (in_ext)
      wr_addr_o = ADDR_W'(EXT_BASE) + (ADDR_W'(slot_q) << 1) + ADDR_W'(idx_q);
    else
      wr_addr_o = ADDR_W'(MAIN_BASE) + (ADDR_W'(slot_q) << 2) + ADDR_W'(main_idx);
  end

  assign wr_en_o   = (state_q == ST_WRITE);
  assign wr_data_o = cmd_q.bytes[idx_q];
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
  assign reject_o  = rej_q;

  a_r1_slot_moves_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(slot_q) |-> done_o);

  a_r2_no_write_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK && !slot_rdy) |=> !wr_en_o);

  a_r3_timeout_after_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (pcnt_q == PM_W'(POLL_MAX) && state_q == ST_IDLE));

  a_r8_reject_when_fw_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !fw_ready_i) |=> (reject_o && !wr_en_o));

  a_r10_single_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, timeout_o, reject_o}));
endmodule

// File: rtl/mbox_writer.sv
module mbox_writer
  import mbox_pkg::*;
#(
  parameter int unsigned NSLOT     = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned MAIN_BASE = 16,
  parameter int unsigned EXT_BASE  = 48,
  parameter int unsigned TICK_DIV  = 50,
  parameter int unsigned POLL_US   = 10,
  parameter int unsigned POLL_MAX  = 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fw_ready_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [7:0]         req_id_i,
  input  logic [2:0]         req_len_i,
  input  logic [39:0]        req_data_i,
  input  logic [7:0]         fw_pend_i,
  input  logic [NSLOT*8-1:0] slot_stat_i,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [7:0]         wr_data_o,
  output logic               done_o,
  output logic               timeout_o,
  output logic               reject_o
);
  logic             tick;
  mbox_cmd_t        cmd;
  logic [NSLOT-1:0] rdy;

  mbox_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  mbox_packer u_pack (
    .id_i  (req_id_i),
    .len_i (req_len_i),
    .data_i(req_data_i),
    .cmd_o (cmd)
  );

  mbox_ready #(.NSLOT(NSLOT)) u_rdy (
    .pend_i(fw_pend_i),
    .stat_i(slot_stat_i),
    .rdy_o (rdy)
  );

  mbox_seq #(
    .NSLOT(NSLOT), .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .EXT_BASE(EXT_BASE),
    .POLL_US(POLL_US), .POLL_MAX(POLL_MAX)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .fw_ready_i (fw_ready_i),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .cmd_i      (cmd),
    .rdy_i      (rdy),
    .wr_en_o    (wr_en_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .done_o     (done_o),
    .timeout_o  (timeout_o),
    .reject_o   (reject_o)
  );
endmodule

// File: tb/mbox_writer_test.sv
`timescale 1ns/1ps
module mbox_writer_test;
  localparam int NSLOT = 4, MAIN = 16, EXT = 48;
  localparam int TDIV = 2, PUS = 3, PMAX = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        fw_ready = 1'b1, valid = 1'b0, ready;
  logic [7:0]  id = '0;
  logic [2:0]  len = '0;
  logic [39:0] data = '0;
  logic [7:0]  pend = '0;
  logic [31:0] stat = '0;
  logic        wr_en, done, tmo, rej;
  logic [7:0]  wr_addr, wr_data;

  always #10 clk = ~clk;

  mbox_writer #(.NSLOT(NSLOT), .ADDR_W(8), .MAIN_BASE(MAIN), .EXT_BASE(EXT),
                .TICK_DIV(TDIV), .POLL_US(PUS), .POLL_MAX(PMAX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .fw_ready_i(fw_ready), .req_valid_i(valid),
    .req_ready_o(ready), .req_id_i(id), .req_len_i(len), .req_data_i(data),
    .fw_pend_i(pend), .slot_stat_i(stat), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .done_o(done), .timeout_o(tmo), .reject_o(rej));

  int checks = 0, errors = 0, wn = 0, exp_slot = 0;
  bit finished = 0;
  logic [7:0] wa [16];
  logic [7:0] wd [16];

  always @(negedge clk) if (wr_en && wn < 16) begin
    wa[wn] = wr_addr; wd[wn] = wr_data; wn++;
  end

  // {id, len, data}
  localparam logic [50:0] VEC [8] = '{
    {8'h12, 3'd1, 40'hFF_FFFF_FFAB},
    {8'hA5, 3'd2, 40'h99_8877_6655},
    {8'h7F, 3'd3, 40'h00_00C3_B2A1},
    {8'h80, 3'd3, 40'hEE_0102_0304},
    {8'h01, 3'd4, 40'hFF_D4C3_B2A1},
    {8'hFF, 3'd5, 40'h5E_4D3C_2B1A},
    {8'h33, 3'd5, 40'h00_0000_0000},
    {8'hC4, 3'd4, 40'h77_1122_3344}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // kind: 0 done, 1 timeout, 2 reject, 3 hang
  task automatic run_req(input logic [7:0] i, input logic [2:0] l, input logic [39:0] d,
                         output int lat, output int kind, output bit rdy0);
    @(negedge clk);
    while (!ready) @(negedge clk);
    wn = 0; id = i; len = l; data = d; valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0; lat = 0; kind = 3; rdy0 = ready;
    while (lat < 200) begin
      if (done) begin kind = 0; break; end
      if (tmo)  begin kind = 1; break; end
      if (rej)  begin kind = 2; break; end
      @(negedge clk); lat++;
    end
  endtask

  task automatic check_writes(input logic [7:0] i, input logic [2:0] l, input logic [39:0] d,
                              input int slot, input string req);
    logic [7:0] b [5];
    logic [7:0] ea [6];
    logic [7:0] ed [6];
    int en = 0;
    for (int k = 0; k < 5; k++) b[k] = (k < int'(l)) ? d[8*k +: 8] : 8'h00;
    if (l >= 1 && l <= 3) begin
      en = 4;
      ed[0] = {1'b0, i[6:0]}; ed[1] = b[0]; ed[2] = b[1]; ed[3] = b[2];
      for (int k = 0; k < 4; k++) ea[k] = 8'(MAIN + 4*slot + k);
    end else if (l == 4 || l == 5) begin
      en = 6;
      ea[0] = 8'(EXT + 2*slot); ea[1] = 8'(EXT + 2*slot + 1);
      ed[0] = b[0]; ed[1] = b[1];
      ed[2] = {1'b1, i[6:0]}; ed[3] = b[2]; ed[4] = b[3]; ed[5] = b[4];
      for (int k = 0; k < 4; k++) ea[k+2] = 8'(MAIN + 4*slot + k);
    end
    chk(wn == en, req, "write count", 64'(wn), 64'(en));
    for (int k = 0; k < en && k < wn; k++) begin
      chk(wa[k] == ea[k], req, "write addr (R6 order)", 64'(wa[k]), 64'(ea[k]));
      chk(wd[k] == ed[k], req, "write data", 64'(wd[k]), 64'(ed[k]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat, kind, n;
    bit r0;
    logic [50:0] v;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R9", "ready in reset", 64'(ready), 64'd1);
    chk({wr_en, done, tmo, rej} == 4'b0, "R10", "outputs in reset", 64'({wr_en, done, tmo, rej}), 64'd0);
    rst_n = 1'b1;

    // table walk: R1 rotation, R4/R5 layout, R6 order, R9 busy, R10 latency
    foreach (VEC[k]) begin
      v = VEC[k];
      run_req(v[50:43], v[42:40], v[39:0], lat, kind, r0);
      n = (v[42:40] >= 3'd4) ? 6 : 4;
      chk(kind == 0, "R1", "outcome done", 64'(kind), 64'd0);
      chk(lat == n + 1, "R10", "done latency", 64'(lat), 64'(n + 1));
      chk(r0 == 1'b0, "R9", "ready while busy", 64'(r0), 64'd0);
      check_writes(v[50:43], v[42:40], v[39:0], exp_slot, (n == 6) ? "R5" : "R4");
      exp_slot = (exp_slot + 1) % NSLOT;
    end

    // R8: reject when controller not ready
    fw_ready = 1'b0;
    run_req(8'h21, 3'd2, 40'h1234, lat, kind, r0);
    chk(kind == 2, "R8", "reject outcome", 64'(kind), 64'd2);
    chk(lat == 0, "R8", "reject latency", 64'(lat), 64'd0);
    chk(wn == 0, "R8", "no writes on reject", 64'(wn), 64'd0);
    fw_ready = 1'b1;
    run_req(8'h22, 3'd1, 40'h9, lat, kind, r0);
    check_writes(8'h22, 3'd1, 40'h9, exp_slot, "R8");
    exp_slot = (exp_slot + 1) % NSLOT;

    // R7: invalid lengths complete without writes and advance slot
    run_req(8'h31, 3'd0, 40'hFF, lat, kind, r0);
    chk(kind == 0 && lat == 1, "R7", "len0 done latency", 64'(lat), 64'd1);
    chk(wn == 0, "R7", "len0 no writes", 64'(wn), 64'd0);
    exp_slot = (exp_slot + 1) % NSLOT;
    run_req(8'h32, 3'd6, 40'hFF, lat, kind, r0);
    chk(kind == 0 && lat == 1, "R7", "len6 done latency", 64'(lat), 64'd1);
    chk(wn == 0, "R7", "len6 no writes", 64'(wn), 64'd0);
    exp_slot = (exp_slot + 1) % NSLOT;
    run_req(8'h33, 3'd3, 40'hABCDEF, lat, kind, r0);
    check_writes(8'h33, 3'd3, 40'hABCDEF, exp_slot, "R7");
    exp_slot = (exp_slot + 1) % NSLOT;

    // R2: another slot's pending bit does not block
    pend = 8'(1 << ((exp_slot + 1) % NSLOT));
    run_req(8'h41, 3'd2, 40'h5566, lat, kind, r0);
    chk(kind == 0 && lat == 5, "R2", "other pend ignored", 64'(lat), 64'd5);
    check_writes(8'h41, 3'd2, 40'h5566, exp_slot, "R2");
    exp_slot = (exp_slot + 1) % NSLOT;
    pend = '0;

    // R2: nonzero status byte holds the slot until cleared
    stat[8*exp_slot +: 8] = 8'h5A;
    fork
      run_req(8'h42, 3'd5, 40'h0102030405, lat, kind, r0);
      begin repeat (12) @(negedge clk); stat = '0; end
    join
    chk(kind == 0, "R2", "done after status clear", 64'(kind), 64'd0);
    chk(lat >= 10, "R2", "held while status busy", 64'(lat), 64'd10);
    check_writes(8'h42, 3'd5, 40'h0102030405, exp_slot, "R2");
    exp_slot = (exp_slot + 1) % NSLOT;

    // R3: timeout, no writes, slot unchanged
    pend = 8'(1 << exp_slot);
    run_req(8'h51, 3'd1, 40'h7, lat, kind, r0);
    chk(kind == 1, "R3", "timeout outcome", 64'(kind), 64'd1);
    chk(lat >= 25 && lat <= 29, "R3", "timeout latency", 64'(lat), 64'd25);
    chk(wn == 0, "R3", "no writes on timeout", 64'(wn), 64'd0);
    pend = '0;
    run_req(8'h52, 3'd4, 40'hA0B0C0D0, lat, kind, r0);
    chk(kind == 0, "R1", "done after timeout", 64'(kind), 64'd0);
    check_writes(8'h52, 3'd4, 40'hA0B0C0D0, exp_slot, "R1");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule